// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a small serial configuration EEPROM that has a three-wire interface: chip select, shift clock, data towards the device and data from the device. A single-cycle request carries the word address and a width selection. The width is 8 address bits for the larger device class or 6 bits for the smaller one. The block starts the read command with an always-one start bit, so the command begins with the three-bit read code `110`. The address follows, most significant bit first. The block then clocks in 16 data bits, most significant first, and returns the word with a one-cycle done pulse.

The shift clock is derived from the system clock. Each high or low half-period lasts a programmable number of system cycles. A value of zero selects a built-in default of 17 cycles, which keeps the shift clock at or below 1 MHz with a 33 MHz system clock.

A typical user reads word 0 with 8 address bits to find the device organisation. It then fetches configuration words one per request, for example three consecutive words holding a station address, each stored low byte first.

Top module: `sprom_reader`

## Requirements
- R1: Out of reset and while idle, `sel_o`, `sclk_o`, `sout_o`, `busy_o` and `done_o` are low and `data_o` is zero. `sclk_o` is never high while `sel_o` is low.
- R2: A request is accepted when `req_i` is high at a rising clock edge while idle. From the next cycle, `busy_o` is high. `sel_o` then stays low for one half-period, and after that is high with `sclk_o` low for one half-period.
- R3: The command is 3+W bits: opcode `110`, then address bits W-1..0, most significant first. W is 8 when `wide_i`=1. W is 6 when `wide_i`=0, and only `addr_i[5:0]` is used. For each bit, `sout_o` holds the bit with `sclk_o` low for a half-period, then with `sclk_o` high for a half-period. `sout_o` only changes while `sclk_o` is low.
- R4: After the command, `sout_o` is low. The block gives 16 shift-clock pulses, each a low half-period followed by a high half-period. A final low half-period ends the sequence. `sin_i` is sampled on the last system cycle of each high half-period. The first sample is bit 15 of `data_o`.
- R5: The block raises `done_o` for exactly one cycle, H·(2·(3+W)+35) cycles after the first busy cycle. During that cycle `sel_o` is low and `busy_o` is still high. In the next cycle the block is idle.
- R6: The half-period H equals `half_i` captured at acceptance. When `half_i` is 0, H is 17.
- R7: While busy, including the done cycle, a request is ignored. Changes to `addr_i`, `wide_i` and `half_i` have no effect on the access in progress.
- R8: `data_o` changes only in the cycle where `done_o` is high, and holds its value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read (taken only while idle) |
| addr_i | input | 8 | Word address |
| wide_i | input | 1 | 1: 8 address bits, 0: 6 address bits |
| half_i | input | 8 | Shift-clock half-period in system cycles, 0 selects 17 |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| data_o | output | 16 | Last word read |
| sel_o | output | 1 | EEPROM chip select |
| sclk_o | output | 1 | EEPROM shift clock |
| sout_o | output | 1 | Serial data to the EEPROM |
| sin_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench defines t=0 as the first cycle after the accepting edge. Each phase then has a fixed place: the select-low and select-high phases are at half-periods 0 and 1. Command bit j occupies half-periods 2+2j and 3+2j. The data pulses and the closing low half-period fill the next 33 half-periods. The done cycle falls exactly at t = H·(2N+35), with N = 9 or 11. The bench counts t itself and compares all pin states against this schedule at every falling clock edge, so a phase that is one cycle early or late is reported in the cycle it happens. The returned word and the cycle after done, which must be idle, are checked at those same fixed offsets. A behavioural EEPROM model answers only when it has received a correct read opcode.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 3;
  localparam logic [OPC_W-1:0] OPC_READ = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEL,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/sprom_timer.sv
module sprom_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R6
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i));
endmodule

// File: rtl/sprom_cmd_shift.sv
module sprom_cmd_shift import sprom_pkg::*; #(
  parameter int AW_MAX    = 8,
  parameter int AW_NARROW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [AW_MAX-1:0] addr_i,
  input  logic              shift_i,
  output logic              nxt_bit_o,
  output logic              last_o
);
  localparam int CMD_W = OPC_W + AW_MAX;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(OPC_W + AW_NARROW);

  logic [CMD_W-1:0] sr_q, sr_d, narrow_img;
  logic [CNT_W-1:0] left_q, left_d;

  // narrow command left-aligned so the MSB is always the next bit out
  generate
    if (AW_MAX > AW_NARROW) begin : g_pad
      assign narrow_img = {OPC_READ, addr_i[AW_NARROW-1:0], {(AW_MAX-AW_NARROW){1'b0}}};
    end else begin : g_nopad
      assign narrow_img = {OPC_READ, addr_i[AW_NARROW-1:0]};
    end
  endgenerate

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    if (load_i) begin
      sr_d   = wide_i ? {OPC_READ, addr_i} : narrow_img;
      left_d = wide_i ? LEN_WIDE : LEN_NARROW;
    end else if (shift_i) begin
      sr_d   = {sr_q[CMD_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end

  assign nxt_bit_o = sr_d[CMD_W-1];
  assign last_o    = (left_q == CNT_W'(1));

  // R3
  cmd_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (left_q != '0));
endmodule

// File: rtl/sprom_rx_shift.sv
module sprom_rx_shift import sprom_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (sample_i) begin
      sr_q  <= {sr_q[WORD_W-2:0], sd_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_W'(WORD_W));

  // R4
  rx_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> !full_o);
endmodule

// File: rtl/sprom_fsm.sv
module sprom_fsm import sprom_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tick_i,
  input  logic cmd_last_i,
  input  logic cmd_nxt_i,
  input  logic rx_full_i,
  output logic busy_o,
  output logic run_o,
  output logic load_o,
  output logic cmd_shift_o,
  output logic rx_sample_o,
  output logic fin_o,
  output logic done_o,
  output logic sel_o,
  output logic sclk_o,
  output logic sout_o
);
  seq_st_e st_q, st_d;
  logic    sel_q, sclk_q, sout_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i)  st_d = ST_PRE;
      ST_PRE:    if (tick_i) st_d = ST_SEL;
      ST_SEL:    if (tick_i) st_d = ST_CMD_LO;
      ST_CMD_LO: if (tick_i) st_d = ST_CMD_HI;
      ST_CMD_HI: if (tick_i) st_d = cmd_last_i ? ST_DAT_LO : ST_CMD_LO;
      ST_DAT_LO: if (tick_i) st_d = rx_full_i ? ST_DONE : ST_DAT_HI;
      ST_DAT_HI: if (tick_i) st_d = ST_DAT_LO;
      ST_DONE:               st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  // pins come from flops loaded with the next-state decode: glitch-free, no added latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= st_d inside {ST_SEL, ST_CMD_LO, ST_CMD_HI, ST_DAT_LO, ST_DAT_HI};
      sclk_q <= st_d inside {ST_CMD_HI, ST_DAT_HI};
      sout_q <= (st_d inside {ST_CMD_LO, ST_CMD_HI}) && cmd_nxt_i;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign run_o       = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign load_o      = (st_q == ST_IDLE) && req_i;
  assign cmd_shift_o = (st_q == ST_CMD_HI) && tick_i;
  assign rx_sample_o = (st_q == ST_DAT_HI) && tick_i;
  assign fin_o       = (st_q == ST_DAT_LO) && tick_i && rx_full_i;
  assign done_o      = (st_q == ST_DONE);
  assign sel_o       = sel_q;
  assign sclk_o      = sclk_q;
  assign sout_o      = sout_q;

  // R1
  sclk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> !sclk_o);
  // R3
  sout_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sout_o) |-> !sclk_o);
  // R2
  start_sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !sel_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R5
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!sel_o && busy_o));
endmodule

// File: rtl/sprom_reader.sv
module sprom_reader import sprom_pkg::*; #(
  parameter int AW_MAX    = 8,
  parameter int AW_NARROW = 6,
  parameter int DIV_W     = 8,
  parameter int HALF_DEF  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW_MAX-1:0] addr_i,
  input  logic              wide_i,
  input  logic [DIV_W-1:0]  half_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o,
  output logic              sel_o,
  output logic              sclk_o,
  output logic              sout_o,
  input  logic              sin_i
);
  localparam logic [DIV_W-1:0] HALF_DEF_V = DIV_W'(HALF_DEF);

  logic              tick, run, load, cmd_shift, cmd_last, cmd_nxt;
  logic              rx_sample, rx_full, fin;
  logic [DIV_W-1:0]  half_q;
  logic [WORD_W-1:0] rx_word, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_DEF_V;
      data_q <= '0;
    end else begin
      if (load) half_q <= (half_i == '0) ? HALF_DEF_V : half_i;
      if (fin)  data_q <= rx_word;
    end
  end

  sprom_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (half_q),
    .tick_o (tick)
  );

  sprom_cmd_shift #(.AW_MAX(AW_MAX), .AW_NARROW(AW_NARROW)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .wide_i    (wide_i),
    .addr_i    (addr_i),
    .shift_i   (cmd_shift),
    .nxt_bit_o (cmd_nxt),
    .last_o    (cmd_last)
  );

  sprom_rx_shift u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (load),
    .sample_i (rx_sample),
    .sd_i     (sin_i),
    .word_o   (rx_word),
    .full_o   (rx_full)
  );

  sprom_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .tick_i      (tick),
    .cmd_last_i  (cmd_last),
    .cmd_nxt_i   (cmd_nxt),
    .rx_full_i   (rx_full),
    .busy_o      (busy_o),
    .run_o       (run),
    .load_o      (load),
    .cmd_shift_o (cmd_shift),
    .rx_sample_o (rx_sample),
    .fin_o       (fin),
    .done_o      (done_o),
    .sel_o       (sel_o),
    .sclk_o      (sclk_o),
    .sout_o      (sout_o)
  );

  assign data_o = data_q;

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> done_o);
  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(half_q));
endmodule

// File: tb/sprom_reader_tb.sv
module sprom_reader_tb;
  localparam int CLK_P = 10;
  localparam int HDEF  = 17;

  logic        clk = 1'b0, rst_ni = 1'b0, req = 1'b0, wide = 1'b0, sin = 1'b0;
  logic [7:0]  addr = '0, half = '0;
  logic        busy, done, sel, sclk, sout;
  logic [15:0] data;
  int          n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sprom_reader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .wide_i(wide),
    .half_i(half), .busy_o(busy), .done_o(done), .data_o(data),
    .sel_o(sel), .sclk_o(sclk), .sout_o(sout), .sin_i(sin)
  );

  function automatic logic [15:0] mem_word(input int a);
    return 16'((a * 11037) ^ 40007);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: act=%h exp=%h", rq, $time, act, exp);
    end
  endtask

  // behavioural EEPROM: shifts in command on rising sclk, then drives data MSB first
  int          ee_aw = 8;
  int          ee_cnt = 0;
  logic [10:0] ee_cmd = '0;
  logic [15:0] ee_sh = '0;
  always @(posedge sclk or negedge sel) begin
    if (!sel) begin
      ee_cnt = 0; ee_cmd = '0; sin = 1'b0;
    end else if (ee_cnt < ee_aw + 3) begin
      ee_cmd = {ee_cmd[9:0], sout};
      ee_cnt++;
      if (ee_cnt == ee_aw + 3) begin
        if (((int'(ee_cmd) >> ee_aw) & 7) == 6) ee_sh = mem_word(int'(ee_cmd) & ((1 << ee_aw) - 1));
        else                                    ee_sh = '0;
      end
    end else begin
      sin   = ee_sh[15];
      ee_sh = {ee_sh[14:0], 1'b0};
    end
  end

  // pin order {sel, sclk, sout, busy, done}
  task automatic run_read(input logic [7:0] a, input bit w, input int hin, input bit poke);
    int h   = (hin == 0) ? HDEF : hin;
    int n   = w ? 11 : 9;
    int tot = h * (2 * n + 35);
    int aw  = w ? 8 : 6;
    logic [10:0] c = w ? {3'b110, a} : {2'b00, 3'b110, a[5:0]};
    ee_aw = w ? 8 : 6;
    @(negedge clk);
    addr = a; wide = w; half = 8'(hin); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t <= tot; t++) begin
      logic [4:0] e;
      string rq;
      int ph = t / h;
      if (ph == 0) begin e = 5'b00010; rq = "R2 select low"; end
      else if (ph == 1) begin e = 5'b10010; rq = "R2 select high"; end
      else if (ph < 2 + 2 * n) begin
        int k = ph - 2;
        e = {1'b1, (k % 2) == 1, c[n - 1 - k / 2], 1'b1, 1'b0};
        rq = "R3 command";
      end else if (t < tot) begin
        int k = ph - 2 - 2 * n;
        e = {1'b1, (k % 2) == 1, 1'b0, 1'b1, 1'b0};
        rq = "R4 data clocks";
      end else begin
        e = 5'b00011; rq = "R5 done";
      end
      chk(rq, {sel, sclk, sout, busy, done}, e);
      if (t == tot) begin
        chk(poke ? "R7 word after ignored request" : "R4 word", data, mem_word(int'(a) & ((1 << aw) - 1)));
        chk(hin == 0 ? "R6 default half-period" : "R6 half-period", done, 1);
      end
      if (poke && t == 3) begin req = 1'b1; addr = ~a; wide = ~w; half = 8'(hin + 1); end
      if (poke && t == 5) req = 1'b0;
      if (poke && t == tot) req = 1'b1;
      @(negedge clk);
    end
    req = 1'b0;
    chk("R5 idle after done", {sel, sclk, sout, busy, done}, 5'b00000);
    @(negedge clk);
    chk("R7 no start from done-cycle request", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {sel, sclk, sout, busy, done}, 5'b00000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {sel, sclk, sout, busy, done}, 5'b00000);
    chk("R1 data reset", data, 16'h0000);
    run_read(8'hA5, 1'b1, 1, 1'b0);
    run_read(8'hC7, 1'b0, 2, 1'b0);
    run_read(8'h00, 1'b1, 3, 1'b1);
    run_read(8'h3F, 1'b0, 0, 1'b0);
    run_read(8'hFF, 1'b1, 1, 1'b1);
    addr = 8'h12; wide = 1'b0; half = 8'd4;
    repeat (25) @(negedge clk);
    chk("R8 data held", data, mem_word(8'hFF));
    chk("R1 idle pins", {sel, sclk, sout, busy, done}, 5'b00000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule